// File: doc/BRIEF.md
# Runtime-Configurable Binary-Field Polynomial Reducer

This block brings a carry-less product back into the field GF(2^m) when the field degree and the middle exponents of the reduction polynomial arrive as inputs rather than being fixed in the wiring. The datapath is sized once for a largest degree `MMAX`. With that sizing it serves any field of degree `1..MMAX` whose modulus is either x^m + x^a + 1 or x^m + x^a + x^b + x^c + 1, provided every middle exponent is below m/2. A multiplier upstream places a product of degree at most 2m−2 in the low bits of `product_i`. One clock edge later the residue appears in the low m bits of `residue_o`.

The product is split at bit m into a high part and a low part. The high part is folded back onto the low part: one copy unshifted for the constant term, and one copy shifted left by each middle exponent. Because every middle exponent is below m/2, the bits that the first fold pushes above m−1 fit entirely below m after a second fold. The block therefore applies exactly two folds and then clears every position at or above m. A degree of zero, or one above `MMAX`, is flagged as an error and yields an all-zero residue.

The block has no state machine. Its only state is the output register, which is cleared by an asynchronous active-low reset, and every cycle it takes a new operand.

Top module: `gf2m_fold_reducer`

## Requirements
- R1: While `rst_n` is low, `residue_o` and `deg_err_o` are both zero.
- R2: Outputs change only at a rising clock edge, and they reflect the inputs present at that edge. A new input does not show at the output before the next edge.
- R3: With `five_term_i`=1, a legal degree and a product below bit 2m−1, `residue_o` equals the product modulo x^m + x^(tap_hi_i) + x^(tap_mid_i) + x^(tap_lo_i) + 1, for distinct taps that are each below m/2.
- R4: With `five_term_i`=0, the result equals the product modulo x^m + x^(tap_hi_i) + 1. The values on `tap_mid_i` and `tap_lo_i` then have no effect on the result.
- R5: Every bit of `residue_o` at position m or above is zero.
- R6: If `deg_i` is 0 or greater than `MMAX`, `deg_err_o` is 1 and `residue_o` is all zero. Otherwise `deg_err_o` is 0.
- R7: Hardware with the default `MMAX`=283 reduces correctly for the degree-163 pentanomial (taps 7,6,3), the degree-233 trinomial (tap 74) and the degree-283 pentanomial (taps 12,7,5).
- R8: A product with no bit set at or above position m is passed through unchanged, and a zero product gives a zero residue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| product_i | input | 2*MMAX-1 | Carry-less product; bits at and above 2m−1 are zero |
| deg_i | input | $clog2(MMAX+1) | Field degree m |
| tap_hi_i | input | $clog2(MMAX+1) | Largest middle exponent (the only one used for trinomials) |
| tap_mid_i | input | $clog2(MMAX+1) | Second middle exponent (pentanomial only) |
| tap_lo_i | input | $clog2(MMAX+1) | Smallest middle exponent (pentanomial only) |
| five_term_i | input | 1 | 1 = pentanomial, 0 = trinomial |
| residue_o | output | MMAX | Reduced value, zero at positions m and above |
| deg_err_o | output | 1 | Degree out of range |

## Verification
In a single cycle, the two folds overlap with the final masking. When the second-largest set product bit sits high enough, the first fold's overflow lands at exactly the positions that the second fold must clear, and the top of the unmasked datapath can still hold bits above m. The bench provokes this with random full-width products on the three standard fields and on hundreds of small random legal fields, where the tap nears m/2. Each residue is judged against a bit-serial long division computed in the bench, together with a separate check that nothing survives above m−1.

// File: rtl/gf2m_red_pkg.sv
package gf2m_red_pkg;
    // Number of fold passes; two suffice when every middle tap is below m/2.
    localparam int FOLD_STAGES = 2;

    typedef enum logic {
        POLY_THREE_TERM = 1'b0,
        POLY_FIVE_TERM  = 1'b1
    } poly_kind_e;
endpackage

// File: rtl/gf2m_fold_stage.sv
module gf2m_fold_stage #(
    parameter int W2 = 565,
    parameter int MW = 9
) (
    input  logic [W2-1:0]          vec_i,
    input  logic [MW-1:0]          deg_i,
    input  logic [MW-1:0]          tap_hi_i,
    input  logic [MW-1:0]          tap_mid_i,
    input  logic [MW-1:0]          tap_lo_i,
    input  gf2m_red_pkg::poly_kind_e kind_i,
    output logic [W2-1:0]          vec_o
);
    logic [W2-1:0] one_w;
    logic [W2-1:0] low_keep;
    logic [W2-1:0] upper;
    logic [W2-1:0] lower;
    logic [W2-1:0] extra;

    always_comb begin
        one_w    = {{(W2-1){1'b0}}, 1'b1};
        low_keep = (one_w << deg_i) - one_w;
        upper    = vec_i >> deg_i;
        lower    = vec_i & low_keep;
        unique case (kind_i)
            gf2m_red_pkg::POLY_FIVE_TERM:  extra = (upper << tap_mid_i) ^ (upper << tap_lo_i);
            gf2m_red_pkg::POLY_THREE_TERM: extra = '0;
            default:                       extra = '0;
        endcase
        vec_o = lower ^ upper ^ (upper << tap_hi_i) ^ extra;
    end
endmodule

// File: rtl/gf2m_low_mask.sv
module gf2m_low_mask #(
    parameter int MMAX = 283,
    parameter int MW   = 9
) (
    input  logic [MMAX-1:0] vec_i,
    input  logic [MW-1:0]   deg_i,
    output logic [MMAX-1:0] vec_o
);
    for (genvar gi = 0; gi < MMAX; gi++) begin : g_bit
        assign vec_o[gi] = vec_i[gi] & (MW'(gi) < deg_i);
    end
endmodule

// File: rtl/gf2m_fold_reducer.sv
module gf2m_fold_reducer #(
    parameter  int MMAX = 283,
    localparam int W2   = 2*MMAX - 1,
    localparam int MW   = $clog2(MMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W2-1:0]   product_i,
    input  logic [MW-1:0]   deg_i,
    input  logic [MW-1:0]   tap_hi_i,
    input  logic [MW-1:0]   tap_mid_i,
    input  logic [MW-1:0]   tap_lo_i,
    input  logic            five_term_i,
    output logic [MMAX-1:0] residue_o,
    output logic            deg_err_o
);
    import gf2m_red_pkg::*;

    poly_kind_e     kind;
    logic           deg_ok;
    logic [W2-1:0]  stage [FOLD_STAGES+1];
    logic [MMAX-1:0] masked;
    logic [MMAX-1:0] prod_lo;

    assign kind     = five_term_i ? POLY_FIVE_TERM : POLY_THREE_TERM;
    assign deg_ok   = (deg_i != '0) && (int'(deg_i) <= MMAX);
    assign stage[0] = product_i;
    assign prod_lo  = product_i[MMAX-1:0];

    for (genvar gk = 0; gk < FOLD_STAGES; gk++) begin : g_fold
        gf2m_fold_stage #(.W2(W2), .MW(MW)) u_fold (
            .vec_i     (stage[gk]),
            .deg_i     (deg_i),
            .tap_hi_i  (tap_hi_i),
            .tap_mid_i (tap_mid_i),
            .tap_lo_i  (tap_lo_i),
            .kind_i    (kind),
            .vec_o     (stage[gk+1])
        );
    end

    gf2m_low_mask #(.MMAX(MMAX), .MW(MW)) u_mask (
        .vec_i (stage[FOLD_STAGES][MMAX-1:0]),
        .deg_i (deg_i),
        .vec_o (masked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            residue_o <= '0;
            deg_err_o <= 1'b0;
        end else begin
            deg_err_o <= !deg_ok;
            residue_o <= deg_ok ? masked : '0;
        end
    end

    // Operand legality, used only to qualify the overflow property below.
    logic legal_op;
    always_comb begin
        legal_op = deg_ok
                && (int'(tap_hi_i) * 2 < int'(deg_i))
                && (!five_term_i || ((int'(tap_mid_i) * 2 < int'(deg_i))
                                  && (int'(tap_lo_i) * 2 < int'(deg_i))))
                && ((product_i >> (2*int'(deg_i) - 1)) == '0);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (residue_o == '0) && !deg_err_o);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        legal_op |-> ((stage[FOLD_STAGES] >> deg_i) == '0));

    p_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !deg_err_o |-> ((residue_o >> $past(deg_i)) == '0));

    p_bad_degree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (($past(deg_i) == '0) || (int'($past(deg_i)) > MMAX))
        |-> deg_err_o && (residue_o == '0));

    p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(deg_i) != '0) && (int'($past(deg_i)) <= MMAX)
        && (($past(product_i) >> $past(deg_i)) == '0)
        |-> (residue_o == $past(prod_lo)) && !deg_err_o);
endmodule

// File: tb/gf2m_fold_reducer_test.sv
`timescale 1ns/1ps
module gf2m_fold_reducer_test;
    localparam int MMAX = 283;
    localparam int W2   = 2*MMAX - 1;
    localparam int MW   = $clog2(MMAX + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W2-1:0]   product_i = '0;
    logic [MW-1:0]   deg_i = '0;
    logic [MW-1:0]   tap_hi_i = '0;
    logic [MW-1:0]   tap_mid_i = '0;
    logic [MW-1:0]   tap_lo_i = '0;
    logic            five_term_i = 1'b0;
    logic [MMAX-1:0] residue_o;
    logic            deg_err_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gf2m_fold_reducer #(.MMAX(MMAX)) uut (.*);

    function automatic logic [MMAX-1:0] long_div(logic [W2-1:0] p, int m, int a, int b, int c, bit five);
        logic [W2-1:0] v = p;
        for (int i = W2-1; i >= m; i--) begin
            if (v[i]) begin
                v[i]       = 1'b0;
                v[i-m]     = ~v[i-m];
                v[i-m+a]   = ~v[i-m+a];
                if (five) begin
                    v[i-m+b] = ~v[i-m+b];
                    v[i-m+c] = ~v[i-m+c];
                end
            end
        end
        return v[MMAX-1:0];
    endfunction

    function automatic logic [W2-1:0] rand_prod(int nbits);
        logic [W2-1:0] v = '0;
        for (int j = 0; j < W2; j++) if (j < nbits) v[j] = 1'($urandom_range(0, 1));
        return v;
    endfunction

    task automatic cmp(string tag, logic [MMAX-1:0] got, logic [MMAX-1:0] exp, logic gerr, logic eerr);
        compared++;
        if (got !== exp || gerr !== eerr) begin
            mismatched++;
            $display("FAIL %s: residue=%h err=%b expected residue=%h err=%b", tag, got, gerr, exp, eerr);
        end
    endtask

    task automatic apply(logic [W2-1:0] p, int m, int a, int b, int c, bit five);
        product_i = p; deg_i = MW'(m); tap_hi_i = MW'(a);
        tap_mid_i = MW'(b); tap_lo_i = MW'(c); five_term_i = five;
    endtask

    // Drive at a falling edge; the result is registered at the next rising edge.
    task automatic run_case(string tag, logic [W2-1:0] p, int m, int a, int b, int c, bit five, int eb, int ec);
        logic [MMAX-1:0] exp;
        bit bad;
        @(negedge clk);
        apply(p, m, a, b, c, five);
        @(negedge clk);
        bad = (m == 0) || (m > MMAX);
        exp = bad ? '0 : long_div(p, m, a, eb, ec, five);
        cmp(tag, residue_o, exp, deg_err_o, bad);
        if (!bad) cmp({tag, "/R5"}, residue_o >> m, '0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        compared++; mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [W2-1:0] pa, pb;
        logic [MMAX-1:0] ea;
        // R1: reset holds outputs low even with a live operand present
        apply(rand_prod(2*163-1), 163, 7, 6, 3, 1'b1);
        repeat (3) @(negedge clk);
        cmp("R1 reset", residue_o, '0, deg_err_o, 1'b0);
        rst_n = 1'b1;

        // R7 / R3 / R4: standard fields on MMAX=283 hardware
        for (int k = 0; k < 40; k++) begin
            run_case("R7 R3 m283", rand_prod(2*283-1), 283, 12, 7, 5, 1'b1, 7, 5);
            run_case("R7 R4 m233", rand_prod(2*233-1), 233, 74, 0, 0, 1'b0, 0, 0);
            run_case("R7 R3 m163", rand_prod(2*163-1), 163, 7, 6, 3, 1'b1, 6, 3);
        end

        // R4: unused taps carry garbage in three-term mode
        for (int k = 0; k < 30; k++)
            run_case("R4 ignore", rand_prod(2*233-1), 233, 74,
                     $urandom_range(1, MMAX-1), $urandom_range(1, MMAX-1), 1'b0, 0, 0);

        // R3 / R4: small random legal fields, taps pushed toward m/2
        for (int k = 0; k < 300; k++) begin
            int m, half, a, b, c;
            bit five;
            m = $urandom_range(8, 40);
            half = (m - 1) / 2;
            five = 1'($urandom_range(0, 1));
            a = (k % 3 == 0) ? half : $urandom_range(3, half);
            b = $urandom_range(2, a - 1);
            c = $urandom_range(1, b - 1);
            if (five) run_case("R3 small", rand_prod(2*m-1), m, a, b, c, 1'b1, b, c);
            else      run_case("R4 small", rand_prod(2*m-1), m, a, b, c, 1'b0, 0, 0);
        end

        // R3: all-ones product, worst-case overflow from the first fold
        run_case("R3 ones283", {W2{1'b1}}, 283, 12, 7, 5, 1'b1, 7, 5);
        run_case("R3 ones163", rand_prod(0) | ((W2'(1) << 325) - 1), 163, 7, 6, 3, 1'b1, 6, 3);

        // R6: degree out of range
        run_case("R6 deg0", rand_prod(40), 0, 1, 0, 0, 1'b0, 0, 0);
        run_case("R6 deg284", rand_prod(500), 284, 12, 7, 5, 1'b1, 7, 5);
        run_case("R6 degmax", rand_prod(500), (1 << MW) - 1, 3, 2, 1, 1'b1, 2, 1);

        // R8: zero product and a product already below x^m
        run_case("R8 zero", '0, 233, 74, 0, 0, 1'b0, 0, 0);
        pa = rand_prod(163);
        run_case("R8 pass", pa, 163, 7, 6, 3, 1'b1, 6, 3);
        cmp("R8 pass value", residue_o, pa[MMAX-1:0], deg_err_o, 1'b0);

        // R2: a new operand does not appear before the next rising edge
        pa = rand_prod(2*283-1);
        pb = rand_prod(2*283-1);
        ea = long_div(pa, 283, 12, 7, 5, 1'b1);
        @(negedge clk);
        apply(pa, 283, 12, 7, 5, 1'b1);
        @(negedge clk);
        apply(pb, 283, 12, 7, 5, 1'b1);
        #1;
        cmp("R2 hold", residue_o, ea, deg_err_o, 1'b0);
        @(negedge clk);
        cmp("R2 update", residue_o, long_div(pb, 283, 12, 7, 5, 1'b1), deg_err_o, 1'b0);

        finish_run();
    end
endmodule